// File: doc/BRIEF.md
# Effective Address Sequencer

This unit turns an addressing-mode code into a finished 16-bit operand address for an 8-bit processor core. A start strobe captures the mode, the program counter and both index registers. The unit then fetches operand bytes and, for the pointer modes, pointer bytes through a single-byte read port. When it has finished, it returns the effective address, the program counter advanced past the operand bytes, and a flag that shows whether indexing or a branch offset moved the address into another 256-byte page.

The memory port carries one read at a time. The unit raises a request with an address and holds both steady until the memory answers with a valid strobe and a data byte. Opcode decoding and reading the final operand are left to the surrounding core. The core starts the unit once per instruction and waits for the one-cycle completion pulse.

Top module: `ea_unit`

## Requirements
- R1: While reset (rst_n low) is applied and after it is released, done, mem_req, ea, pc_out and page_cross are all zero until the first operation completes.
- R2: Only one read is outstanding at a time. mem_req and mem_addr stay unchanged until a cycle with mem_valid high, and mem_req is low while idle. The number of accepted reads per mode is: 0 for immediate, 1 for the zero-page and relative modes, 2 for the absolute modes, 3 for the zero-page pointer modes, and 4 for absolute indirect and (abs,X).
- R3: Immediate (mode 0), and every unused code 13 to 15, gives ea equal to the start PC and pc_out equal to PC+1.
- R4: Zero page (mode 1), zero page plus X (mode 2) and zero page plus Y (mode 3) read one byte at PC. The index sum wraps to 8 bits, so ea[15:8] is 0, and pc_out is PC+1.
- R5: Absolute (mode 4) reads the low byte at PC and the high byte at PC+1, and pc_out is PC+2. Absolute plus X (mode 5) and plus Y (mode 6) add the index with a full 16-bit carry.
- R6: Relative (mode 7) reads one offset byte at PC. The byte is sign-extended and added to PC+1, and pc_out is PC+1.
- R7: Indexed indirect (mode 8) reads the pointer low byte at (zp+X) mod 256 and the pointer high byte at (zp+X+1) mod 256. ea is that pointer.
- R8: Indirect indexed (mode 9) reads the pointer from zp and (zp+1) mod 256, then adds Y with a 16-bit carry.
- R9: Absolute indirect (mode 10) reads a 16-bit operand, then reads the target low byte at that operand and the high byte at operand+1 (16-bit carry). pc_out is PC+2.
- R10: Zero-page indirect (mode 11) reads the pointer from zp and (zp+1) mod 256, and ea is that pointer.
- R11: Absolute indexed indirect (mode 12) reads a pointer at the absolute operand and operand+1, then adds X to the fetched pointer.
- R12: page_cross is 1 only for modes 5, 6, 7, 9 and 12, and only when (ea XOR base) AND 0xFF00 is nonzero. The base is the unindexed address, or PC+1 for relative.
- R13: done is a one-cycle pulse. ea, pc_out and page_cross keep their values until the next done. A start that arrives while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| mode | input | 4 | Addressing-mode code |
| pc_in | input | 16 | Program counter pointing at the first operand byte |
| x_in | input | 8 | X index register |
| y_in | input | 8 | Y index register |
| mem_data | input | 8 | Read data byte |
| mem_valid | input | 1 | Read data valid, completes the pending read |
| mem_req | output | 1 | Read request |
| mem_addr | output | 16 | Read address |
| ea | output | 16 | Effective address |
| pc_out | output | 16 | Program counter after the operand bytes |
| done | output | 1 | Completion pulse |
| page_cross | output | 1 | Indexing or branch moved into another page |

## Verification
Every mode is run with random PC, index and memory contents, and with a random number of wait cycles before each read completes. This separates a sequencer that holds its request correctly from one that moves ahead early, and it confirms the read count for each mode. Directed cases place the zero-page pointer at 0xFF and make zp+X land on 0xFF, which tells 8-bit wrapping apart from a 16-bit carry. They also place an absolute-indirect operand at the end of a page, which shows that the carry moves into the high byte there. Further cases force relative offsets and index values that do or do not cross a page, which checks the crossing flag in both directions. A second start issued mid-operation checks that it has no effect on the results.

// File: rtl/ea_unit.sv
module ea_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [3:0]  mode,
  input  logic [15:0] pc_in,
  input  logic [7:0]  x_in,
  input  logic [7:0]  y_in,
  input  logic [7:0]  mem_data,
  input  logic        mem_valid,
  output logic        mem_req,
  output logic [15:0] mem_addr,
  output logic [15:0] ea,
  output logic [15:0] pc_out,
  output logic        done,
  output logic        page_cross
);
  localparam logic [3:0] M_IMM = 4'd0, M_ZP = 4'd1, M_ZPX = 4'd2, M_ZPY = 4'd3,
                         M_ABS = 4'd4, M_ABX = 4'd5, M_ABY = 4'd6, M_REL = 4'd7,
                         M_IZX = 4'd8, M_IZY = 4'd9, M_IND = 4'd10, M_IZP = 4'd11,
                         M_AIX = 4'd12;

  typedef enum logic [2:0] {S_IDLE, S_OP0, S_OP1, S_PLO, S_PHI, S_FIN} st_t;
  st_t st;

  logic [3:0]  md;
  logic [15:0] pc_r, op, ptr, base, offs, npc;
  logic [7:0]  xr, yr;
  logic        xing;

  wire two_byte = (md == M_ABS) || (md == M_ABX) || (md == M_ABY) || (md == M_IND) || (md == M_AIX);
  wire zp_ptr   = (md == M_IZX) || (md == M_IZY) || (md == M_IZP);
  wire [7:0] zloc = (md == M_IZX) ? 8'(op[7:0] + xr) : op[7:0];
  wire busy = (st != S_IDLE);

  assign mem_req = (st == S_OP0) || (st == S_OP1) || (st == S_PLO) || (st == S_PHI);

  always_comb begin
    case (st)
      S_OP0, S_OP1: mem_addr = pc_r;
      S_PLO:        mem_addr = zp_ptr ? {8'h00, zloc} : op;
      S_PHI:        mem_addr = zp_ptr ? {8'h00, 8'(zloc + 8'd1)} : op + 16'd1;
      default:      mem_addr = 16'h0000;
    endcase
  end

  always_comb begin
    base = pc_r;
    offs = 16'h0000;
    xing = 1'b0;
    npc  = pc_r;
    case (md)
      M_ZP:  base = {8'h00, op[7:0]};
      M_ZPX: base = {8'h00, 8'(op[7:0] + xr)};
      M_ZPY: base = {8'h00, 8'(op[7:0] + yr)};
      M_ABS: base = op;
      M_ABX: begin base = op; offs = {8'h00, xr}; xing = 1'b1; end
      M_ABY: begin base = op; offs = {8'h00, yr}; xing = 1'b1; end
      M_REL: begin base = pc_r; offs = {{8{op[7]}}, op[7:0]}; xing = 1'b1; end
      M_IZX, M_IND, M_IZP: base = ptr;
      M_IZY: begin base = ptr; offs = {8'h00, yr}; xing = 1'b1; end
      M_AIX: begin base = ptr; offs = {8'h00, xr}; xing = 1'b1; end
      default: npc = pc_r + 16'd1;
    endcase
  end

  wire [15:0] sum = base + offs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      md <= '0; pc_r <= '0; op <= '0; ptr <= '0; xr <= '0; yr <= '0;
      ea <= '0; pc_out <= '0; done <= 1'b0; page_cross <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          md <= mode; pc_r <= pc_in; xr <= x_in; yr <= y_in;
          op <= '0; ptr <= '0;
          st <= (mode == M_IMM || mode > M_AIX) ? S_FIN : S_OP0;
        end
        S_OP0: if (mem_valid) begin
          op   <= {8'h00, mem_data};
          pc_r <= pc_r + 16'd1;
          st   <= two_byte ? S_OP1 : (zp_ptr ? S_PLO : S_FIN);
        end
        S_OP1: if (mem_valid) begin
          op[15:8] <= mem_data;
          pc_r     <= pc_r + 16'd1;
          st       <= (md == M_IND || md == M_AIX) ? S_PLO : S_FIN;
        end
        S_PLO: if (mem_valid) begin
          ptr[7:0] <= mem_data;
          st       <= S_PHI;
        end
        S_PHI: if (mem_valid) begin
          ptr[15:8] <= mem_data;
          st        <= S_FIN;
        end
        default: begin
          ea         <= sum;
          pc_out     <= npc;
          page_cross <= xing && (((sum ^ base) & 16'hFF00) != 16'h0000);
          done       <= 1'b1;
          st         <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [3:0]  mode,
  input logic [15:0] pc_in,
  input logic        busy,
  input logic        mem_req,
  input logic [15:0] mem_addr,
  input logic        mem_valid,
  input logic        done,
  input logic [15:0] ea,
  input logic [15:0] pc_out,
  input logic        page_cross
);
  logic [3:0]  mode_l;
  logic [15:0] pc_l;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_l <= '0;
      pc_l   <= '0;
    end else if (start && !busy) begin
      mode_l <= mode;
      pc_l   <= pc_in;
    end
  end

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid |=> mem_req && $stable(mem_addr));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R13
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> done || ($stable(ea) && $stable(pc_out) && $stable(page_cross)));

  // R4
  zp_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && (mode_l == 4'd1 || mode_l == 4'd2 || mode_l == 4'd3) |-> ea[15:8] == 8'h00);

  // R5
  abs_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && mode_l == 4'd4 |-> pc_out == pc_l + 16'd2);

  // R12
  no_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !(mode_l == 4'd5 || mode_l == 4'd6 || mode_l == 4'd7 || mode_l == 4'd9 || mode_l == 4'd12)
    |-> !page_cross);
endmodule

bind ea_unit ea_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .pc_in(pc_in), .busy(busy),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .done(done),
  .ea(ea), .pc_out(pc_out), .page_cross(page_cross)
);

// File: tb/sim_ea_unit.sv
module sim_ea_unit;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [3:0] mode = '0;
  logic [15:0] pc_in = '0;
  logic [7:0] x_in = '0, y_in = '0, mem_data = '0;
  logic mem_valid = 1'b0;
  logic mem_req, done, page_cross;
  logic [15:0] mem_addr, ea, pc_out;

  int checks = 0, errors = 0, cycles = 0, rd_cnt = 0;
  logic [7:0] salt = 8'h3C;

  always #10 clk = ~clk;

  ea_unit u0 (.clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .pc_in(pc_in),
    .x_in(x_in), .y_in(y_in), .mem_data(mem_data), .mem_valid(mem_valid),
    .mem_req(mem_req), .mem_addr(mem_addr), .ea(ea), .pc_out(pc_out),
    .done(done), .page_cross(page_cross));

  function automatic logic [7:0] memf(input logic [15:0] a);
    return 8'(a[7:0] * 8'd29) ^ 8'(a[15:8] * 8'd71) ^ salt;
  endfunction

  always @(negedge clk) begin
    mem_valid = mem_req && ($urandom_range(0, 2) != 0);
    mem_data  = memf(mem_addr);
    if (mem_req && mem_valid) rd_cnt++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] m);
    case (m)
      4'd1, 4'd2, 4'd3: return "R4";
      4'd4, 4'd5, 4'd6: return "R5";
      4'd7:  return "R6";
      4'd8:  return "R7";
      4'd9:  return "R8";
      4'd10: return "R9";
      4'd11: return "R10";
      4'd12: return "R11";
      default: return "R3";
    endcase
  endfunction

  task automatic model(input logic [3:0] m, input logic [15:0] pc, input logic [7:0] x, input logic [7:0] y,
                       output logic [15:0] e, output logic [15:0] np, output logic c, output int n);
    logic [15:0] base, off, op, p;
    logic [7:0] z, loc;
    logic xg;
    xg = 1'b0; off = '0; n = 0; np = pc; base = pc;
    z = memf(pc);
    op = {memf(pc + 16'd1), z};
    case (m)
      4'd1, 4'd2, 4'd3: begin
        np = pc + 16'd1; n = 1;
        loc = (m == 4'd2) ? 8'(z + x) : (m == 4'd3) ? 8'(z + y) : z;
        base = {8'h00, loc};
      end
      4'd4, 4'd5, 4'd6: begin
        np = pc + 16'd2; n = 2; base = op;
        if (m == 4'd5) begin off = {8'h00, x}; xg = 1'b1; end
        if (m == 4'd6) begin off = {8'h00, y}; xg = 1'b1; end
      end
      4'd7: begin
        np = pc + 16'd1; n = 1; base = np; off = {{8{z[7]}}, z}; xg = 1'b1;
      end
      4'd8, 4'd9, 4'd11: begin
        np = pc + 16'd1; n = 3;
        loc = (m == 4'd8) ? 8'(z + x) : z;
        p = {memf({8'h00, 8'(loc + 8'd1)}), memf({8'h00, loc})};
        base = p;
        if (m == 4'd9) begin off = {8'h00, y}; xg = 1'b1; end
      end
      4'd10, 4'd12: begin
        np = pc + 16'd2; n = 4;
        p = {memf(op + 16'd1), memf(op)};
        base = p;
        if (m == 4'd12) begin off = {8'h00, x}; xg = 1'b1; end
      end
      default: begin np = pc + 16'd1; n = 0; end
    endcase
    e = base + off;
    c = xg && (((e ^ base) & 16'hFF00) != 16'h0000);
  endtask

  task automatic run(input logic [3:0] m, input logic [15:0] pc, input logic [7:0] x, input logic [7:0] y,
                     input logic poke);
    logic [15:0] e, np;
    logic c;
    int n, t;
    model(m, pc, x, y, e, np, c, n);
    @(negedge clk);
    rd_cnt = 0;
    start = 1'b1; mode = m; pc_in = pc; x_in = x; y_in = y;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R13: second start mid-operation must be ignored
      start = 1'b1; mode = 4'd0; pc_in = ~pc; x_in = ~x; y_in = ~y;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (!done && t < 100) begin @(negedge clk); t++; end
    chk(done, "R13 done", {31'd0, done}, 32'd1);
    chk(ea == e, req_of(m), {16'd0, ea}, {16'd0, e});
    chk(pc_out == np, req_of(m), {16'd0, pc_out}, {16'd0, np});
    chk(page_cross == c, "R12", {31'd0, page_cross}, {31'd0, c});
    chk(rd_cnt == n, "R2 reads", rd_cnt, n);
  endtask

  function automatic logic [15:0] find_pc(input logic [7:0] want, input logic [15:0] from);
    for (int i = 0; i < 65536; i++) begin
      logic [15:0] a = from + 16'(i);
      if (memf(a) == want) return a;
    end
    return from;
  endfunction

  initial begin
    logic [15:0] hold_ea, pc;
    void'($urandom(32'd77));
    repeat (3) @(negedge clk);
    // R1
    chk(!done && !mem_req && ea == 0 && pc_out == 0 && !page_cross, "R1 in reset",
        {done, mem_req, page_cross, 13'd0, ea}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !mem_req && ea == 0 && pc_out == 0 && !page_cross, "R1 after reset",
        {done, mem_req, page_cross, 13'd0, pc_out}, 32'd0);

    // R3 immediate and unused codes
    run(4'd0, 16'hFFFF, 8'h00, 8'h00, 1'b0);
    run(4'd14, 16'h1234, 8'h10, 8'h20, 1'b0);
    // R4 zero page indexed wrap
    run(4'd2, 16'h0400, 8'hFF, 8'h00, 1'b0);
    run(4'd3, 16'h0401, 8'h00, 8'hF0, 1'b0);
    // R7 pointer location at 0xFF wraps high byte to 0x00
    run(4'd8, 16'h0500, 8'(8'hFF - memf(16'h0500)), 8'h00, 1'b0);
    // R8 and R10 pointer at zp 0xFF
    pc = find_pc(8'hFF, 16'h0600);
    run(4'd9, pc, 8'h00, 8'hFF, 1'b0);
    run(4'd11, pc, 8'h00, 8'h00, 1'b0);
    // R9 operand at end of a page: high byte from next page
    run(4'd10, pc, 8'h00, 8'h00, 1'b0);
    // R11
    run(4'd12, pc, 8'hFF, 8'h00, 1'b0);
    // R6 negative offset crossing a page, and positive offset
    pc = find_pc(8'h80, 16'h2000);
    run(4'd7, pc, 8'h00, 8'h00, 1'b0);
    pc = find_pc(8'h01, 16'h3000);
    run(4'd7, pc, 8'h00, 8'h00, 1'b0);
    // R5 indexed with and without a carry into the high byte
    run(4'd5, 16'h0700, 8'hFF, 8'h00, 1'b0);
    run(4'd6, 16'h0700, 8'h00, 8'h00, 1'b0);
    run(4'd4, 16'hFFFF, 8'h00, 8'h00, 1'b0);
    // R13 ignored start while busy
    run(4'd10, 16'h0800, 8'h00, 8'h00, 1'b1);
    run(4'd9, 16'h0900, 8'h00, 8'h33, 1'b1);

    // R13 outputs hold after done
    hold_ea = ea;
    repeat (4) @(negedge clk);
    chk(ea == hold_ea && !done, "R13 hold", {15'd0, done, ea}, {16'd0, hold_ea});

    for (int k = 0; k < 400; k++) begin
      if (k % 25 == 0) salt = 8'($urandom);
      run(4'($urandom_range(0, 15)), 16'($urandom), 8'($urandom), 8'($urandom), k % 37 == 5);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule